// File: doc/BRIEF.md
# Serial Pin Extender Controller

This block adds a bank of remote pins that sit on an external chain of shift registers and reach the chip over four wires. Software sets one control word with an enable, a bit-clock divider and a pin count given in groups of eight. From then on the block runs frames without stopping. Each frame starts with a load strobe that lasts one bit-clock period, so the remote chain latches its inputs. The block then moves one output bit out and one input bit in for each pin position.

Register reads and writes use a small word-addressed port with combinational read data. A write to a bank's value address sets the pins that are driven out. A read of the same address returns the inputs gathered in the last complete frame. A second address for each bank returns the output latch. The output latch is copied when shifting starts, and the gathered inputs become visible only when a frame finishes. Software therefore always sees a whole frame, never a mix of two.

Top module: `serial_pin_extender`

## Requirements
- R1: The control word is at address 0. Bit 0 is the enable, bits [31:16] are the divider D, and bits [9:6] give the group count G (pins = 8*G). A read of address 0 returns these fields and 0 in every other bit.
- R2: While frames run, ser_clk has a period of 2*(D+1) clock cycles, with D+1 cycles low and D+1 cycles high.
- R3: Every frame starts with ser_load high for exactly one ser_clk period, and ser_dout stays low during that period. When the enable is 0 or G is 0, ser_clk, ser_load and ser_dout are all low.
- R4: After the load period, 8*G output bits are shifted out with pin 0 first. ser_dout changes only on falling edges of ser_clk.
- R5: ser_din is sampled on each rising edge of ser_clk in the shift phase. The k-th sample is input pin k.
- R6: Reading value address 4+b returns input pins [32b+31:32b]. These bits change only when a frame completes, and pins at or above 8*G read 0.
- R7: A write to value address 4+b sets output latch bank b. Readback address 8+b returns that latch. Writes to readback addresses are ignored.
- R8: The output latch is copied when shifting starts. A write during a frame takes effect from the next frame.
- R9: A group count above NUM_BANKS*4 is treated as NUM_BANKS*4.
- R10: Addresses 1 to 3, and value or readback addresses of banks that do not exist, read 0.
- R11: Clearing the enable in the middle of a frame stops the link on the next cycle and leaves the input values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Word address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ser_clk | output | 1 | Serial bit clock |
| ser_load | output | 1 | Frame load strobe to the remote chain |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data from the remote chain |

## Verification
The half-period property assumes the divider does not change while the link runs. The stimulus only rewrites the control word after it has cleared the enable and waited a few cycles. The dout-timing property assumes the enable stays set across the cycles it compares. For this reason, disabling is the only control change made during a frame. The bench models the remote chain: it drives ser_din only after it sees a falling ser_clk, so the input is stable at the sampling edge.

// File: rtl/spx_pkg.sv
package spx_pkg;
    localparam int unsigned ADDR_W     = 4;
    localparam int unsigned BANK_W     = 32;
    localparam int unsigned DIV_W      = 16;
    localparam int unsigned DIV_LSB    = 16;
    localparam int unsigned CNT_LSB    = 6;
    localparam int unsigned EN_BIT     = 0;
    localparam int unsigned A_VAL_BASE = 4;
    localparam int unsigned A_RB_BASE  = 8;
    localparam logic [ADDR_W-1:0] A_CTRL = '0;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_LOAD,
        FR_SHIFT
    } frame_state_e;
endpackage

// File: rtl/spx_baud.sv
module spx_baud (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic [spx_pkg::DIV_W-1:0] div,
    output logic                      sclk,
    output logic                      tick_rise,
    output logic                      tick_fall
);
    import spx_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } baud_t;

    baud_t b_d, b_q;

    always_comb begin
        b_d       = b_q;
        tick_rise = 1'b0;
        tick_fall = 1'b0;
        if (!run) begin
            b_d = '0;
        end else if (b_q.cnt >= div) begin
            b_d.cnt   = '0;
            b_d.sclk  = ~b_q.sclk;
            tick_rise = ~b_q.sclk;
            tick_fall = b_q.sclk;
        end else begin
            b_d.cnt = b_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign sclk = b_q.sclk;
endmodule

// File: rtl/spx_frame.sv
module spx_frame #(
    parameter int unsigned PINS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    tick_rise,
    input  logic                    tick_fall,
    input  logic [$clog2(PINS)-1:0] last_idx,
    input  logic [PINS-1:0]         latch,
    input  logic                    ser_din,
    output logic                    active,
    output logic                    ser_load,
    output logic                    ser_dout,
    output logic [PINS-1:0]         in_word
);
    import spx_pkg::*;

    localparam int unsigned IDX_W = $clog2(PINS);

    typedef struct packed {
        frame_state_e     st;
        logic [IDX_W-1:0] idx;
        logic [PINS-1:0]  osh;
        logic [PINS-1:0]  cap;
        logic [PINS-1:0]  inw;
        logic             load;
        logic             dout;
    } frame_t;

    frame_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!run) begin
            f_d.st   = FR_IDLE;
            f_d.load = 1'b0;
            f_d.dout = 1'b0;
            f_d.idx  = '0;
        end else begin
            case (f_q.st)
                FR_IDLE: begin
                    f_d.st   = FR_LOAD;
                    f_d.load = 1'b1;
                    f_d.dout = 1'b0;
                    f_d.cap  = '0;
                end
                FR_LOAD: begin
                    if (tick_fall) begin
                        f_d.st   = FR_SHIFT;
                        f_d.load = 1'b0;
                        f_d.idx  = '0;
                        f_d.dout = latch[0];
                        f_d.osh  = latch >> 1;
                    end
                end
                FR_SHIFT: begin
                    if (tick_rise) begin
                        f_d.cap[f_q.idx] = ser_din;
                        if (f_q.idx >= last_idx) f_d.inw = f_d.cap;
                    end
                    if (tick_fall) begin
                        if (f_q.idx >= last_idx) begin
                            f_d.st   = FR_LOAD;
                            f_d.load = 1'b1;
                            f_d.dout = 1'b0;
                            f_d.cap  = '0;
                        end else begin
                            f_d.idx  = f_q.idx + IDX_W'(1);
                            f_d.dout = f_q.osh[0];
                            f_d.osh  = f_q.osh >> 1;
                        end
                    end
                end
                default: f_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign active   = (f_q.st != FR_IDLE);
    assign ser_load = f_q.load;
    assign ser_dout = f_q.dout;
    assign in_word  = f_q.inw;
endmodule

// File: rtl/spx_regs.sv
module spx_regs #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [spx_pkg::ADDR_W-1:0] reg_addr,
    input  logic                       reg_we,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic [NUM_BANKS*32-1:0]    in_word,
    output logic                       en,
    output logic [spx_pkg::DIV_W-1:0]  div,
    output logic [CNT_W-1:0]           grp,
    output logic [NUM_BANKS*32-1:0]    latch
);
    import spx_pkg::*;

    localparam int unsigned PINS = NUM_BANKS * BANK_W;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] grp;
        logic [PINS-1:0]  latch;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            if (reg_addr == A_CTRL) begin
                r_d.en  = reg_wdata[EN_BIT];
                r_d.div = reg_wdata[DIV_LSB +: DIV_W];
                r_d.grp = reg_wdata[CNT_LSB +: CNT_W];
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (reg_addr == ADDR_W'(A_VAL_BASE + b))
                    r_d.latch[b*BANK_W +: BANK_W] = reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[EN_BIT]            = r_q.en;
            reg_rdata[DIV_LSB +: DIV_W]  = r_q.div;
            reg_rdata[CNT_LSB +: CNT_W]  = r_q.grp;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(A_VAL_BASE + b))
                reg_rdata = in_word[b*BANK_W +: BANK_W];
            if (reg_addr == ADDR_W'(A_RB_BASE + b))
                reg_rdata = r_q.latch[b*BANK_W +: BANK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en    = r_q.en;
    assign div   = r_q.div;
    assign grp   = r_q.grp;
    assign latch = r_q.latch;
endmodule

// File: rtl/serial_pin_extender.sv
module serial_pin_extender #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned CNT_W     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ser_clk,
    output logic        ser_load,
    output logic        ser_dout,
    input  logic        ser_din
);
    import spx_pkg::*;

    localparam int unsigned PINS       = NUM_BANKS * BANK_W;
    localparam int unsigned IDX_W      = $clog2(PINS);
    localparam int unsigned MAX_GROUPS = PINS / 8;

    logic             en_w;
    logic [DIV_W-1:0] div_w;
    logic [CNT_W-1:0] grp_w;
    logic [CNT_W-1:0] grp_eff;
    logic [PINS-1:0]  latch_w;
    logic [PINS-1:0]  inw_w;
    logic [IDX_W-1:0] last_idx;
    logic             run_w;
    logic             baud_run;
    logic             frame_active;
    logic             tick_rise;
    logic             tick_fall;

    spx_regs #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_word   (inw_w),
        .en        (en_w),
        .div       (div_w),
        .grp       (grp_w),
        .latch     (latch_w)
    );

    assign grp_eff  = (grp_w > CNT_W'(MAX_GROUPS)) ? CNT_W'(MAX_GROUPS) : grp_w;
    assign last_idx = IDX_W'({grp_eff - CNT_W'(1), 3'b111});
    assign run_w    = en_w && (grp_w != '0);
    assign baud_run = run_w && frame_active;

    spx_baud u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (baud_run),
        .div       (div_w),
        .sclk      (ser_clk),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    spx_frame #(.PINS(PINS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall),
        .last_idx  (last_idx),
        .latch     (latch_w),
        .ser_din   (ser_din),
        .active    (frame_active),
        .ser_load  (ser_load),
        .ser_dout  (ser_dout),
        .in_word   (inw_w)
    );
endmodule

// File: rtl/spx_checker.sv
module spx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        baud_run,
    input logic [15:0] div,
    input logic [3:0]  reg_addr,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        ser_clk,
    input logic        ser_load,
    input logic        ser_dout
);
    import spx_pkg::*;

    logic        prev_clk_q;
    logic [16:0] hp_cnt_q;
    logic        hp_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk_q <= 1'b0;
            hp_cnt_q   <= '0;
            hp_ok_q    <= 1'b0;
        end else begin
            prev_clk_q <= ser_clk;
            if (!baud_run) begin
                hp_cnt_q <= '0;
                hp_ok_q  <= 1'b0;
            end else if (ser_clk != prev_clk_q) begin
                hp_cnt_q <= 17'd1;
                hp_ok_q  <= 1'b1;
            end else if (hp_cnt_q != '1) begin
                hp_cnt_q <= hp_cnt_q + 17'd1;
            end
        end
    end

    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_run && hp_ok_q && ser_clk != prev_clk_q) |-> hp_cnt_q == ({1'b0, div} + 17'd1));

    p_quiet_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ser_clk && !ser_load && !ser_dout));

    p_load_dout_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> !ser_dout);

    p_dout_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_run && $past(baud_run) && !$stable(ser_dout)) |-> $fell(ser_clk));

    p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we && reg_addr == 4'(A_VAL_BASE)) && reg_addr == 4'(A_RB_BASE))
        |-> reg_rdata == $past(reg_wdata));
endmodule

bind serial_pin_extender spx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_w),
    .baud_run  (baud_run),
    .div       (div_w),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ser_clk   (ser_clk),
    .ser_load  (ser_load),
    .ser_dout  (ser_dout)
);

// File: tb/tb_serial_pin_extender.sv
module tb_serial_pin_extender;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ser_clk, ser_load, ser_dout;
    logic        ser_din = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_pin_extender dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
        .ser_load(ser_load), .ser_dout(ser_dout), .ser_din(ser_din)
    );

    // remote chain model
    logic [PINS-1:0] remote_in = '0;
    logic [PINS-1:0] rx_cur = '0;
    logic [PINS-1:0] rx_done = '0;
    int bitcnt = 0, bits_done = 0, loads = 0, cyc = 0, rise_at = 0;
    int last_period = 0, ld_run = 0, last_ld = 0;
    logic prev_sclk = 1'b0, prev_ld = 1'b0;

    initial forever begin
        @(negedge clk);
        cyc++;
        if (ser_load) ld_run++;
        else if (prev_ld) begin last_ld = ld_run; ld_run = 0; end
        if (ser_clk && !prev_sclk) begin
            last_period = cyc - rise_at;
            rise_at = cyc;
            if (ser_load) begin
                if (bitcnt > 0) begin rx_done = rx_cur; bits_done = bitcnt; end
                rx_cur = '0; bitcnt = 0; loads++;
            end else begin
                if (bitcnt < PINS) rx_cur[bitcnt] = ser_dout;
                bitcnt++;
            end
        end
        if (!ser_clk && prev_sclk) ser_din = (bitcnt < PINS) ? remote_in[bitcnt] : 1'b0;
        prev_sclk = ser_clk;
        prev_ld = ser_load;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(bit e, int d, int g);
        return (32'(d) << 16) | (32'(g) << 6) | 32'(e);
    endfunction

    task automatic wait_loads(int n);
        int target = loads + n;
        while (loads < target) @(negedge clk);
    endtask

    task automatic stop_link();
        wr(0, 32'h0);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R3", ser_clk, 0, "ser_clk after reset");
        check("R3", ser_load, 0, "ser_load after reset");
        check("R3", ser_dout, 0, "ser_dout after reset");
        rd(0, v); check("R1", v, 0, "ctrl after reset");
        rd(4, v); check("R6", v, 0, "value after reset");
        rd(8, v); check("R7", v, 0, "readback after reset");
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF); rd(0, v); check("R1", v, 32'hFFFF_03C1, "ctrl all ones");
        wr(0, 32'h1234_0145); rd(0, v); check("R1", v, 32'h1234_0141, "ctrl mixed");
        stop_link();
    endtask

    task automatic t_map();
        logic [31:0] v;
        rd(2, v);  check("R10", v, 0, "addr 2");
        rd(6, v);  check("R10", v, 0, "absent value bank");
        rd(10, v); check("R10", v, 0, "absent readback bank");
        rd(15, v); check("R10", v, 0, "addr 15");
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(4, 32'hA5A5_1234); wr(5, 32'h0F0F_C3C3);
        rd(8, v); check("R7", v, 32'hA5A5_1234, "readback bank0");
        rd(9, v); check("R7", v, 32'h0F0F_C3C3, "readback bank1");
        rd(4, v); check("R6", v, 0, "value reads inputs not latch");
        wr(8, 32'hDEAD_BEEF);
        rd(8, v); check("R7", v, 32'hA5A5_1234, "readback write ignored");
    endtask

    task automatic t_frame();
        logic [31:0] v;
        remote_in = {32'h0, 32'hFFFF_5AC3};
        wr(0, ctl(1, 1, 2));
        wait_loads(1);
        while (bitcnt < 8) @(negedge clk);
        rd(4, v); check("R6", v, 0, "value unchanged mid-frame");
        wait_loads(1);
        check("R4", bits_done, 16, "bits per frame G=2");
        check("R4", rx_done[31:0], 32'h0000_1234, "shifted outputs G=2");
        check("R2", last_period, 4, "period D=1");
        check("R3", last_ld, 4, "load length D=1");
        rd(4, v); check("R5", v, 32'h0000_5AC3, "captured inputs G=2");
        rd(5, v); check("R6", v, 0, "bank1 beyond count");
        stop_link();
    endtask

    task automatic t_fast();
        logic [31:0] v;
        remote_in = {32'h0, 32'h0000_FF96};
        wr(0, ctl(1, 0, 1));
        wait_loads(3);
        check("R4", bits_done, 8, "bits per frame G=1");
        check("R4", rx_done[31:0], 32'h0000_0034, "shifted outputs G=1");
        check("R2", last_period, 2, "period D=0");
        check("R3", last_ld, 2, "load length D=0");
        rd(4, v); check("R6", v, 32'h0000_0096, "upper pins read 0");
        stop_link();
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        remote_in = {32'h8001_7FFE, 32'h3C3C_6699};
        wr(0, ctl(1, 0, 15));
        wait_loads(2);
        check("R9", bits_done, 64, "clamped frame length");
        check("R9", rx_done[31:0], 32'hA5A5_1234, "clamped out bank0");
        check("R9", rx_done[63:32], 32'h0F0F_C3C3, "clamped out bank1");
        rd(4, v); check("R9", v, 32'h3C3C_6699, "clamped in bank0");
        rd(5, v); check("R9", v, 32'h8001_7FFE, "clamped in bank1");
        stop_link();
    endtask

    task automatic t_snapshot();
        wr(0, ctl(1, 2, 1));
        wait_loads(1);
        while (bitcnt < 2) @(negedge clk);
        wr(4, 32'h0000_00C5);
        wait_loads(1);
        check("R8", rx_done[7:0], 8'h34, "mid-frame write not in current frame");
        wait_loads(1);
        check("R8", rx_done[7:0], 8'hC5, "mid-frame write in next frame");
        stop_link();
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int l0, r0;
        remote_in = {32'h0, 32'h0000_00E7};
        wr(0, ctl(1, 1, 1));
        wait_loads(1);
        while (bitcnt < 4) @(negedge clk);
        wr(0, 32'h0);
        @(negedge clk);
        check("R11", ser_clk, 0, "sclk low after abort");
        check("R11", ser_load, 0, "load low after abort");
        check("R11", ser_dout, 0, "dout low after abort");
        l0 = loads; r0 = rise_at;
        repeat (40) @(negedge clk);
        check("R11", loads, l0, "no load after abort");
        check("R11", rise_at, r0, "no sclk rise after abort");
        rd(4, v); check("R11", v, 32'h0000_0099, "partial frame not committed");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ctrl_fields();
        t_map();
        t_latch();
        t_frame();
        t_fast();
        t_clamp();
        t_snapshot();
        t_abort();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule